// File: doc/BRIEF.md
# Serial Flash Write-Protection Unit

This block keeps the protection field and the lock bit of a serial flash status register and judges, request by request, whether a program, a sector erase or a chip erase may touch the array. A three-bit level code marks a power-of-two slice at the top of the address space as read-only. Level 0 leaves everything writable, and the top level covers the whole array. A fourth, reserved protection bit is stored but plays no part in the address decision.

A status-register write loads the protection field and the lock bit from a data byte. When the lock bit is set and the active-low write-protect pin is held low, such writes are refused and a one-cycle reject pulse follows. When the pin is high, the lock bit does not matter. The grant outputs are combinational on the stored bits, so a command decoder can sample them in the same cycle that it raises a request strobe.

Top module: `flash_wr_guard`

## Requirements
- R1: After a synchronous reset, the protection bits read 4'b0111 (the whole array is protected), the lock bit reads 0 and the reject flag reads 0.
- R2: With level code L = prot_bits[2:0], a program or sector-erase grant is high only when the request is high and the address is below the protected start. That start is 2^ADDR_W for L=0, 2^ADDR_W - 2^(ADDR_W-7+L) for L=1..6, and 0 for L=7. For 22 bits, the starts for L=1..6 are 3F0000h, 3E0000h, 3C0000h, 380000h, 300000h and 200000h. A sector erase is judged at its sector base address, which is the address with its low SECTOR_W bits cleared.
- R3: A status write (sr_wr high for one cycle) is accepted when wp_n is 1 or the lock bit is 0. On acceptance, sr_wdata[5:2] loads prot_bits[3:0] and sr_wdata[7] loads the lock bit, and the new values are visible after the next rising clock edge.
- R4: When wp_n is 0 and the lock bit is 1, a status write changes neither the protection bits nor the lock bit, and the grants keep following the old level.
- R5: When wp_n is 1, the lock bit has no effect: status writes are accepted with the lock set, and they can clear the lock.
- R6: prot_bits[3] is stored but is ignored by the address decision of R2.
- R7: chip_grant is high only when chip_erase_req is high and all four protection bits are 0. A set prot_bits[3] alone denies a chip erase.
- R8: Each grant is low whenever its own request strobe is low.
- R9: wr_reject is high for exactly the one cycle after a refused status write and stays 0 after an accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_wr | input | 1 | Status-register write strobe |
| sr_wdata | input | 8 | Status data byte (bits 5..2 protection, bit 7 lock) |
| wp_n | input | 1 | Write-protect pin level, active low |
| addr | input | ADDR_W (22) | Target address of a program or sector erase |
| pgm_req | input | 1 | Program request strobe |
| sec_erase_req | input | 1 | Sector-erase request strobe |
| chip_erase_req | input | 1 | Chip-erase request strobe |
| prot_bits | output | 4 | Current protection bits |
| lock_bit | output | 1 | Current lock bit |
| pgm_grant | output | 1 | Program allowed |
| sec_grant | output | 1 | Sector erase allowed |
| chip_grant | output | 1 | Chip erase allowed |
| wr_reject | output | 1 | One-cycle pulse after a refused status write |

## Verification
A status write is driven on a falling edge and takes effect at the following rising edge. The stored bits and the reject pulse are therefore sampled at the next falling edge, and the reject flag is sampled again one cycle later to confirm that it has cleared. The grants settle in the same cycle as the request and the address, so the bench samples them 1 ns after driving the inputs, away from any rising edge. The sweep covers every level code with the reserved bit both clear and set, and probes the addresses at and around each protected start.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int BP_W      = 4;
  localparam int CODE_W    = 3;
  localparam int FLD_BP_LO = 2;
  localparam int FLD_LOCK  = 7;
  localparam logic [BP_W-1:0] BP_RESET = 4'b0111;

  typedef struct packed {
    logic            lock;
    logic [BP_W-1:0] bp;
  } guard_state_t;
endpackage

// File: rtl/wp_status_reg.sv
module wp_status_reg
  import wp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [7:0]      wdata,
  input  logic            wp_n,
  output logic [BP_W-1:0] bp,
  output logic            lock,
  output logic            reject
);
  guard_state_t st_q;
  logic         may_write;
  logic         unused_bits;

  assign unused_bits = ^{wdata[1:0], wdata[6]};
  assign may_write   = wp_n | ~st_q.lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q.bp   <= BP_RESET;
      st_q.lock <= 1'b0;
      reject    <= 1'b0;
    end else begin
      reject <= wr & ~may_write;
      if (wr && may_write) begin
        st_q.bp   <= wdata[FLD_BP_LO +: BP_W];
        st_q.lock <= wdata[FLD_LOCK];
      end
    end
  end

  assign bp   = st_q.bp;
  assign lock = st_q.lock;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (bp == BP_RESET) && !lock && !reject);

  p_accept_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && (wp_n || !lock)) |=> (bp == $past(wdata[FLD_BP_LO +: BP_W])) && (lock == $past(wdata[FLD_LOCK])) && !reject);

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && !wp_n && lock) |=> $stable(bp) && $stable(lock) && reject);

  p_reject_cause_r9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> !reject);
endmodule

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
  parameter int ADDR_W = 22,
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  output logic [ADDR_W:0]   start
);
  localparam int LEVELS = (1 << CODE_W) - 1;
  localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(1) << ADDR_W;

  logic [ADDR_W:0] start_tab [1 << CODE_W];

  for (genvar k = 0; k < (1 << CODE_W); k++) begin : g_lvl
    if (k == 0) begin : g_none
      assign start_tab[k] = FULL;
    end else begin : g_frac
      assign start_tab[k] = FULL - ((ADDR_W+1)'(1) << (ADDR_W - LEVELS + k));
    end
  end

  assign start = start_tab[code];

  always_comb begin
    p_none_open_r2: assert (code != '0 || start == FULL);
    p_all_closed_r2: assert (code != CODE_W'(LEVELS) || start == '0);
  end
endmodule

// File: rtl/wp_access_check.sv
module wp_access_check #(
  parameter int ADDR_W = 22,
  parameter int ALIGN_W = 0
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W:0]   start,
  output logic              grant
);
  logic [ADDR_W-1:0] base;

  if (ALIGN_W > 0) begin : g_align
    assign base = {addr[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  end else begin : g_plain
    assign base = addr;
  end

  assign grant = req & ({1'b0, base} < start);

  always_comb begin
    p_idle_low_r8: assert (req || !grant);
  end
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int SECTOR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sr_wr,
  input  logic [7:0]        sr_wdata,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pgm_req,
  input  logic              sec_erase_req,
  input  logic              chip_erase_req,
  output logic [3:0]        prot_bits,
  output logic              lock_bit,
  output logic              pgm_grant,
  output logic              sec_grant,
  output logic              chip_grant,
  output logic              wr_reject
);
  logic [BP_W-1:0] bp;
  logic [ADDR_W:0] prot_start;

  wp_status_reg u_status (
    .clk(clk), .rst(rst), .wr(sr_wr), .wdata(sr_wdata), .wp_n(wp_n),
    .bp(bp), .lock(lock_bit), .reject(wr_reject)
  );

  wp_region_decode #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_decode (
    .code(bp[CODE_W-1:0]), .start(prot_start)
  );

  wp_access_check #(.ADDR_W(ADDR_W), .ALIGN_W(0)) u_pgm_chk (
    .req(pgm_req), .addr(addr), .start(prot_start), .grant(pgm_grant)
  );

  wp_access_check #(.ADDR_W(ADDR_W), .ALIGN_W(SECTOR_W)) u_sec_chk (
    .req(sec_erase_req), .addr(addr), .start(prot_start), .grant(sec_grant)
  );

  assign chip_grant = chip_erase_req & (bp == '0);
  assign prot_bits  = bp;

  p_chip_clear_r7: assert property (@(posedge clk) disable iff (rst)
    chip_grant |-> (prot_bits == 4'b0000));

  p_full_deny_r2: assert property (@(posedge clk) disable iff (rst)
    (prot_bits[2:0] == 3'b111) |-> (!pgm_grant && !sec_grant));

  p_open_allow_r2: assert property (@(posedge clk) disable iff (rst)
    (prot_bits[2:0] == 3'b000 && pgm_req) |-> pgm_grant);
endmodule

// File: tb/flash_wr_guard_bench.sv
`timescale 1ns/1ps
module flash_wr_guard_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sr_wr = 1'b0;
  logic [7:0] sr_wdata = 8'h00;
  logic wp_n = 1'b1;
  logic [21:0] addr = '0;
  logic pgm_req = 1'b0, sec_erase_req = 1'b0, chip_erase_req = 1'b0;
  logic [3:0] prot_bits;
  logic lock_bit, pgm_grant, sec_grant, chip_grant, wr_reject;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_wr_guard u_flash_wr_guard (
    .clk(clk), .rst(rst), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .wp_n(wp_n),
    .addr(addr), .pgm_req(pgm_req), .sec_erase_req(sec_erase_req),
    .chip_erase_req(chip_erase_req), .prot_bits(prot_bits), .lock_bit(lock_bit),
    .pgm_grant(pgm_grant), .sec_grant(sec_grant), .chip_grant(chip_grant),
    .wr_reject(wr_reject)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint start_of(input int code);
    if (code == 0) return 64'd4194304;
    return 64'd4194304 - (64'd1 << (15 + code));
  endfunction

  // status write: drive on falling edge, sample at the next falling edge
  task automatic sr_write(input logic [7:0] d, input logic pin);
    @(negedge clk);
    sr_wdata = d; wp_n = pin; sr_wr = 1'b1;
    @(negedge clk);
    sr_wr = 1'b0;
  endtask

  task automatic probe(input int code, input int a, input string tag);
    longint base;
    bit exp_p, exp_s;
    base  = longint'(a) & ~64'hFFF;
    exp_p = longint'(a) < start_of(code);
    exp_s = base < start_of(code);
    @(negedge clk);
    addr = 22'(a); pgm_req = 1'b1; sec_erase_req = 1'b1;
    #1;
    check(pgm_grant == exp_p, {tag, " R2 pgm"}, int'(pgm_grant), int'(exp_p));
    check(sec_grant == exp_s, {tag, " R2 sec"}, int'(sec_grant), int'(exp_s));
    pgm_req = 1'b0; sec_erase_req = 1'b0;
    #1;
    check(!pgm_grant && !sec_grant, "R8 idle grants", int'({pgm_grant, sec_grant}), 0);
  endtask

  task automatic probe_chip(input logic [3:0] bits);
    @(negedge clk);
    chip_erase_req = 1'b1;
    #1;
    check(chip_grant == (bits == 4'd0), "R7 chip erase", int'(chip_grant), int'(bits == 4'd0));
    chip_erase_req = 1'b0;
    #1;
    check(!chip_grant, "R8 chip idle", int'(chip_grant), 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(prot_bits == 4'b0111, "R1 reset bits", int'(prot_bits), 7);
    check(lock_bit == 1'b0, "R1 reset lock", int'(lock_bit), 0);
    check(wr_reject == 1'b0, "R1 reset reject", int'(wr_reject), 0);
    probe(7, 0, "R1 reset level");
    probe_chip(4'b0111);

    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 8; c++) begin
        logic [3:0] bits;
        longint s;
        bits = {1'(r), 3'(c)};
        sr_write({2'b00, bits, 2'b00}, 1'b0);
        check(prot_bits == bits, "R3 accepted write", int'(prot_bits), int'(bits));
        check(wr_reject == 1'b0, "R9 no reject on accept", int'(wr_reject), 0);
        s = start_of(c);
        probe(c, 0, r ? "R6 bp3 set" : "sweep");
        probe(c, 22'h3FFFFF, r ? "R6 bp3 set" : "sweep");
        if (s > 0 && s < 64'd4194304) begin
          probe(c, int'(s) - 1, "boundary below");
          probe(c, int'(s), "boundary at");
          probe(c, int'(s) + 12'hFFF, "boundary sector");
        end
        probe_chip(bits);
      end
    end

    // lock set with pin high, then locked write with pin low
    sr_write(8'b1000_1100, 1'b1);
    check(prot_bits == 4'b0011 && lock_bit, "R3 set lock", int'({lock_bit, prot_bits}), 5'h13);
    sr_write(8'b0000_0000, 1'b0);
    check(prot_bits == 4'b0011, "R4 locked bits", int'(prot_bits), 3);
    check(lock_bit == 1'b1, "R4 locked lock", int'(lock_bit), 1);
    check(wr_reject == 1'b1, "R9 reject pulse", int'(wr_reject), 1);
    @(negedge clk);
    check(wr_reject == 1'b0, "R9 reject one cycle", int'(wr_reject), 0);
    probe(3, 22'h3BFFFF, "R4 old level");
    probe(3, 22'h3C0000, "R4 old level");
    probe_chip(4'b0011);

    // pin high: lock ignored
    sr_write(8'b1001_0100, 1'b1);
    check(prot_bits == 4'b0101 && lock_bit, "R5 write while locked", int'({lock_bit, prot_bits}), 5'h15);
    check(wr_reject == 1'b0, "R5 no reject", int'(wr_reject), 0);
    sr_write(8'b0000_0000, 1'b1);
    check(prot_bits == 4'b0000 && !lock_bit, "R5 clear lock", int'({lock_bit, prot_bits}), 0);
    probe_chip(4'b0000);

    // unlocked, pin low: accepted
    sr_write(8'b0000_1000, 1'b0);
    check(prot_bits == 4'b0010, "R3 pin low unlocked", int'(prot_bits), 2);
    check(wr_reject == 1'b0, "R9 no reject unlocked", int'(wr_reject), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule